// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four peripheral request lines gets the system bus for a DMA transfer, and runs the bus handover with the host processor. When an enabled channel asks for service, the arbiter raises a bus-hold request. It waits for the host's hold grant. It then picks one channel and drives that channel's acknowledge line for as long as the transfer lasts. The grant ends when the channel withdraws its request or an external transfer-done strobe arrives. The hold request then drops for a clock before the next arbitration round.

An 8-bit command word, loaded through a one-cycle write strobe, controls the arbiter. It can shut the arbiter off, choose fixed or rotating priority, and set the active level of the request inputs and of the acknowledge outputs independently. The arbiter does not take a command write while a grant is in progress, so the grant's polarity and priority cannot change mid-transfer. Such a write is held back and applied when the grant ends.

Top module: `dmaarb_top`

## Requirements
- R1: While reset is asserted and after it is released, the command word is 0x00, `bus_hold_req` is low and every `chan_ack_out` bit is high (inactive for active-low acknowledges).
- R2: With command bit 2 set, the arbiter never raises `bus_hold_req` from idle, whatever the request inputs do.
- R3: Command bit 6 sets request polarity. 0 means a channel requests when its input is 1, and 1 means it requests when its input is 0.
- R4: Command bit 7 sets acknowledge polarity. 0 means active low and 1 means active high. At most one channel is active at a time, and every other output sits at the inactive level.
- R5: `bus_hold_req` rises on the clock after an active request is seen while enabled and not granted. An acknowledge is asserted only on the clock after `bus_hold_gnt` is sampled high while the hold is pending.
- R6: Fixed priority (bit 4 = 0) grants the lowest-numbered active channel.
- R7: Rotating priority (bit 4 = 1) searches from the channel after the last granted one, wrapping from 3 to 0. The last-granted channel resets to 3 and is updated on every grant in either mode.
- R8: A grant holds the same channel until its request goes inactive or `xfer_done_in` is sampled high. On the next clock, the hold request and the acknowledge drop for exactly one clock if a request is still pending.
- R9: A command write during a grant is deferred until the grant ends. The latest deferred write wins, and a write on the clock the grant ends beats a deferred one.
- R10: If all requests vanish or the arbiter is disabled while the hold is pending and not yet granted, `bus_hold_req` falls on the next clock with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Command write strobe |
| cfg_wdata | input | 8 | Command write data |
| chan_req_in | input | 4 | Per-channel DMA request, polarity per command bit 6 |
| bus_hold_gnt | input | 1 | Host grants the bus |
| xfer_done_in | input | 1 | Ends the current grant |
| bus_hold_req | output | 1 | Request to the host for the bus |
| chan_ack_out | output | 4 | Per-channel acknowledge, polarity per command bit 7 |

## Verification
The assertions assume the host follows a clean handshake. It raises `bus_hold_gnt` only while `bus_hold_req` is high, and it holds the grant until the hold request falls. The arbiter's own transitions are checked against the request vector as conditioned by the polarity in force when it was sampled. The bench's host model sets the grant only after it sees the hold request and clears it as soon as the hold drops. Random command words keep bit 2 mostly clear so that grants happen often, and they vary priority and both polarities freely.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned BIT_DIS  = 2;
  localparam int unsigned BIT_ROT  = 4;
  localparam int unsigned BIT_RPOL = 6;
  localparam int unsigned BIT_APOL = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_GRANT = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dmaarb_rst_sync.sv
module dmaarb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dmaarb_cmd_reg.sv
module dmaarb_cmd_reg #(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             busy_i,
  input  logic             release_i,
  output logic [CMD_W-1:0] cmd_o
);
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [CMD_W-1:0] pend_q, pend_d;
  logic             pv_q, pv_d;
  logic             cmd_en, pend_en;

  // next-state
  always_comb begin
    cmd_d  = cmd_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    if (release_i) begin
      if (wr_en)     cmd_d = wr_data;
      else if (pv_q) cmd_d = pend_q;
      pv_d = 1'b0;
    end else if (busy_i) begin
      if (wr_en) begin
        pend_d = wr_data;
        pv_d   = 1'b1;
      end
    end else if (wr_en) begin
      cmd_d = wr_data;
    end
  end

  assign cmd_en  = (release_i & (wr_en | pv_q)) | (~busy_i & wr_en);
  assign pend_en = release_i | (busy_i & wr_en);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign cmd_o = cmd_q;

  // R9: command word frozen through a grant that is not ending
  assert_cmd_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !release_i) |=> $stable(cmd_q));

  // R9: a deferred word never outlives the grant that deferred it
  assert_pend_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> !pv_q);
endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rotate_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output logic              pick_vld_o,
  output logic [IDX_W-1:0]  pick_idx_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] start_idx;
  int unsigned      cand;

  always_comb begin
    if (!rotate_i)                 start_idx = '0;
    else if (last_idx_i == TOP_IDX) start_idx = '0;
    else                           start_idx = IDX_W'(last_idx_i + 1'b1);
  end

  always_comb begin
    pick_vld_o = 1'b0;
    pick_idx_o = '0;
    cand       = 0;
    for (int unsigned k = 0; k < NUM_CH; k++) begin
      cand = (int'(start_idx) + k) % NUM_CH;
      if (!pick_vld_o && req_i[cand]) begin
        pick_vld_o = 1'b1;
        pick_idx_o = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/dmaarb_seq.sv
module dmaarb_seq
  import dmaarb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [NUM_CH-1:0] req_act_i,
  input  logic              hold_gnt_i,
  input  logic              done_i,
  input  logic              pick_vld_i,
  input  logic [IDX_W-1:0]  pick_idx_i,
  output logic              hold_req_o,
  output logic              grant_vld_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic [IDX_W-1:0]  last_idx_o,
  output logic              busy_o,
  output logic              release_o
);
  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] win_q, win_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             win_en;
  logic             grant_end;

  assign grant_end = (st_q == ST_GRANT) && (!req_act_i[win_q] || done_i);

  // next-state
  always_comb begin
    st_d   = st_q;
    win_d  = win_q;
    last_d = last_q;
    win_en = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_GAP: begin
        if (enable_i && pick_vld_i) st_d = ST_HOLD;
        else                        st_d = ST_IDLE;
      end
      ST_HOLD: begin
        if (!enable_i || !pick_vld_i) begin
          st_d = ST_IDLE;
        end else if (hold_gnt_i) begin
          st_d   = ST_GRANT;
          win_d  = pick_idx_i;
          last_d = pick_idx_i;
          win_en = 1'b1;
        end
      end
      ST_GRANT: begin
        if (grant_end) st_d = ST_GAP;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      last_q <= IDX_W'(NUM_CH - 1);
    end else if (win_en) begin
      win_q  <= win_d;
      last_q <= last_d;
    end
  end

  assign hold_req_o  = (st_q == ST_HOLD) || (st_q == ST_GRANT);
  assign grant_vld_o = (st_q == ST_GRANT);
  assign grant_idx_o = win_q;
  assign last_idx_o  = last_q;
  assign busy_o      = (st_q == ST_GRANT);
  assign release_o   = grant_end;

  // R5: a grant starts only from a pending hold that saw the host grant
  assert_grant_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GRANT && $past(st_q) != ST_GRANT) |->
      ($past(hold_gnt_i) && $past(st_q) == ST_HOLD));

  // R8: transfer-done drops the hold on the next clock
  assert_done_drops_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GRANT && done_i) |=> !hold_req_o);

  // R8: the granted channel does not change within a grant
  assert_win_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GRANT) |=> (st_q != ST_GRANT || $stable(win_q)));

  // R10: a pending hold with nothing to serve is withdrawn
  assert_hold_withdrawn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !pick_vld_i) |=> !hold_req_o);
endmodule

// File: rtl/dmaarb_top.sv
module dmaarb_top
  import dmaarb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CMD_W-1:0]  cfg_wdata,
  input  logic [NUM_CH-1:0] chan_req_in,
  input  logic              bus_hold_gnt,
  input  logic              xfer_done_in,
  output logic              bus_hold_req,
  output logic [NUM_CH-1:0] chan_ack_out
);
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              rst_sync_n;
  logic [CMD_W-1:0]  cmd_q;
  logic [NUM_CH-1:0] req_act;
  logic [NUM_CH-1:0] grant_oh;
  logic              pick_vld;
  logic [IDX_W-1:0]  pick_idx;
  logic              grant_vld;
  logic [IDX_W-1:0]  grant_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              busy;
  logic              release_w;

  dmaarb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  dmaarb_cmd_reg #(.CMD_W(CMD_W)) u_cmd_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (cfg_we),
    .wr_data   (cfg_wdata),
    .busy_i    (busy),
    .release_i (release_w),
    .cmd_o     (cmd_q)
  );

  // per-channel polarity handling
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign req_act[g]      = chan_req_in[g] ^ cmd_q[BIT_RPOL];
    assign grant_oh[g]     = grant_vld && (grant_idx == IDX_W'(g));
    assign chan_ack_out[g] = grant_oh[g] ^ ~cmd_q[BIT_APOL];
  end

  dmaarb_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .req_i      (req_act),
    .rotate_i   (cmd_q[BIT_ROT]),
    .last_idx_i (last_idx),
    .pick_vld_o (pick_vld),
    .pick_idx_o (pick_idx)
  );

  dmaarb_seq #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .enable_i    (~cmd_q[BIT_DIS]),
    .req_act_i   (req_act),
    .hold_gnt_i  (bus_hold_gnt),
    .done_i      (xfer_done_in),
    .pick_vld_i  (pick_vld),
    .pick_idx_i  (pick_idx),
    .hold_req_o  (bus_hold_req),
    .grant_vld_o (grant_vld),
    .grant_idx_o (grant_idx),
    .last_idx_o  (last_idx),
    .busy_o      (busy),
    .release_o   (release_w)
  );

  // R2: disabled and idle stays idle when no write intervenes
  assert_off_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_q[BIT_DIS] && !cfg_we && !bus_hold_req) |=> !bus_hold_req);

  // R3: the granted channel was requesting at the polarity then in force
  assert_grant_on_active_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (grant_vld && !$past(grant_vld)) |-> |($past(req_act) & grant_oh));

  // R4: at most one acknowledge at its active level
  assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_q[BIT_APOL] ? $onehot0(chan_ack_out) : $onehot0(~chan_ack_out));

  // R6: the picker only names a requesting channel
  assert_pick_requested_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pick_vld |-> req_act[pick_idx]);
endmodule

// File: tb/dmaarb_top_bench.sv
`timescale 1ns/1ps
module dmaarb_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [3:0] chan_req_in;
  logic       bus_hold_gnt;
  logic       xfer_done_in;
  logic       bus_hold_req;
  logic [3:0] chan_ack_out;

  always #2.5 clk = ~clk;

  dmaarb_top u_dmaarb_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .chan_req_in  (chan_req_in),
    .bus_hold_gnt (bus_hold_gnt),
    .xfer_done_in (xfer_done_in),
    .bus_hold_req (bus_hold_req),
    .chan_ack_out (chan_ack_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit ack_en = 1'b1;
  int ack_pct = 100;

  // reference state: 0 idle, 1 hold pending, 2 granted, 3 gap
  int       m_st;
  logic [7:0] m_cmd, m_pend;
  bit       m_pv;
  int       m_win, m_last;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int pick_ch(logic [3:0] act, logic rot, int last);
    int s;
    s = rot ? (last + 1) % 4 : 0;
    for (int k = 0; k < 4; k++) if (act[(s + k) % 4]) return (s + k) % 4;
    return -1;
  endfunction

  function automatic logic [3:0] exp_ack();
    logic [3:0] oh;
    oh = (m_st == 2) ? (4'b0001 << m_win) : 4'b0000;
    return m_cmd[7] ? oh : ~oh;
  endfunction

  function automatic logic exp_hold();
    return (m_st == 1) || (m_st == 2);
  endfunction

  task automatic model_step();
    logic [3:0] act;
    logic [7:0] n_cmd, n_pend;
    bit n_pv, rel, en;
    int p, n_st, n_win, n_last;
    act    = m_cmd[6] ? ~chan_req_in : chan_req_in;
    en     = !m_cmd[2];
    p      = pick_ch(act, m_cmd[4], m_last);
    rel    = (m_st == 2) && (!act[m_win] || xfer_done_in);
    n_cmd  = m_cmd; n_pend = m_pend; n_pv = m_pv;
    if (rel) begin
      if (cfg_we) n_cmd = cfg_wdata; else if (m_pv) n_cmd = m_pend;
      n_pv = 1'b0;
    end else if (m_st == 2) begin
      if (cfg_we) begin n_pend = cfg_wdata; n_pv = 1'b1; end
    end else if (cfg_we) begin
      n_cmd = cfg_wdata;
    end
    n_st = m_st; n_win = m_win; n_last = m_last;
    case (m_st)
      0, 3: n_st = (en && p >= 0) ? 1 : 0;
      1: begin
        if (!en || p < 0) n_st = 0;
        else if (bus_hold_gnt) begin n_st = 2; n_win = p; n_last = p; end
      end
      default: if (rel) n_st = 3;
    endcase
    m_st = n_st; m_win = n_win; m_last = n_last;
    m_cmd = n_cmd; m_pend = n_pend; m_pv = n_pv;
  endtask

  task automatic tick(input string tag);
    if (!bus_hold_req) bus_hold_gnt = 1'b0;
    else if (ack_en && ($urandom % 100) < ack_pct) bus_hold_gnt = 1'b1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(tag, "hold_req", 32'(bus_hold_req), 32'(exp_hold()));
    chk(tag, "ack_out", 32'(chan_ack_out), 32'(exp_ack()));
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; chan_req_in = 4'h0;
    bus_hold_gnt = 1'b0; xfer_done_in = 1'b0;
    m_st = 0; m_cmd = 8'h00; m_pend = 8'h00; m_pv = 1'b0; m_win = 0; m_last = 3;
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk("R1", "hold_req", 32'(bus_hold_req), 32'h0);
    chk("R1", "ack_out", 32'(chan_ack_out), 32'hF);
    rst_n = 1'b1;
    ticks(3, "R1");
    chk("R1", "ack_out", 32'(chan_ack_out), 32'hF);

    // R6 fixed priority: channels 2 and 3 request, 2 wins
    chan_req_in = 4'b1100;
    ticks(4, "R6");
    chk("R6", "ack_out", 32'(chan_ack_out), 32'hB);
    // R8 withdraw: one-clock gap, then re-raise for channel 3
    chan_req_in = 4'b1000;
    tick("R8");
    chk("R8", "hold_req gap", 32'(bus_hold_req), 32'h0);
    tick("R8");
    chk("R8", "hold_req reraise", 32'(bus_hold_req), 32'h1);
    ticks(2, "R6");
    chk("R6", "ack_out", 32'(chan_ack_out), 32'h7);

    // R9 writes during a grant are deferred; the later one wins
    wr(8'h80); tick("R9");
    chk("R9", "ack_out deferred", 32'(chan_ack_out), 32'h7);
    wr(8'h90); tick("R9");
    chk("R9", "ack_out deferred", 32'(chan_ack_out), 32'h7);
    chan_req_in = 4'b0000; tick("R9");
    chk("R9", "ack_out applied", 32'(chan_ack_out), 32'h0);

    // R7 rotating, last granted 3: channels 1 and 3 -> 1
    chan_req_in = 4'b1010;
    ticks(3, "R7");
    chk("R7", "ack_out", 32'(chan_ack_out), 32'h2);
    // last granted 1: channels 0 and 3 -> 3 (fixed would pick 0)
    chan_req_in = 4'b1001;
    ticks(4, "R7");
    chk("R7", "ack_out", 32'(chan_ack_out), 32'h8);
    chan_req_in = 4'b0000;
    ticks(2, "R7");

    // R3 active-low requests: all-ones is no request
    wr(8'h40); tick("R3");
    chan_req_in = 4'hF;
    ticks(3, "R3");
    chk("R3", "hold_req", 32'(bus_hold_req), 32'h0);
    chan_req_in = 4'b1101;
    ticks(4, "R3");
    chk("R3", "ack_out", 32'(chan_ack_out), 32'hD);

    // R2 disabled: all channels active, no hold
    chan_req_in = 4'hF; ticks(2, "R2");
    wr(8'h44); tick("R2");
    chan_req_in = 4'h0;
    ticks(5, "R2");
    chk("R2", "hold_req", 32'(bus_hold_req), 32'h0);
    chk("R2", "ack_out", 32'(chan_ack_out), 32'hF);

    // R10 pending hold withdrawn: requests vanish, then disable
    ack_en = 1'b0;
    wr(8'h00); tick("R10");
    chan_req_in = 4'b0001; ticks(2, "R10");
    chk("R10", "hold_req", 32'(bus_hold_req), 32'h1);
    chan_req_in = 4'b0000; tick("R10");
    chk("R10", "hold_req", 32'(bus_hold_req), 32'h0);
    chan_req_in = 4'b0001; ticks(2, "R10");
    wr(8'h04); ticks(2, "R10");
    chk("R10", "hold_req", 32'(bus_hold_req), 32'h0);
    chk("R10", "ack_out", 32'(chan_ack_out), 32'hF);

    // R8 transfer-done with request still present; R5 grant after host ack
    ack_en = 1'b1;
    wr(8'h00); tick("R5");
    ticks(3, "R5");
    chk("R5", "ack_out", 32'(chan_ack_out), 32'hE);
    xfer_done_in = 1'b1; tick("R8");
    chk("R8", "hold_req", 32'(bus_hold_req), 32'h0);
    xfer_done_in = 1'b0; tick("R8");
    chk("R8", "hold_req", 32'(bus_hold_req), 32'h1);
    ticks(2, "R8");

    // R9 write on the ending clock beats a deferred one
    wr(8'h80); tick("R9");
    wr(8'h00); chan_req_in = 4'b0000; tick("R9");
    chk("R9", "ack_out", 32'(chan_ack_out), 32'hF);

    // random traffic
    ack_pct = 50;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 100) < 30) chan_req_in = 4'($urandom);
      xfer_done_in = (($urandom % 100) < 5);
      if (($urandom % 100) < 3)
        wr((8'($urandom) & 8'hD0) | ((($urandom % 8) == 0) ? 8'h04 : 8'h00));
      tick("R4 R5 R7 R8");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule